// File: doc/BRIEF.md
# Sampling Phase Tuning Sweep Engine

This block finds a good sampling point for a receive clock whose phase can be set in N equal steps around one full turn. A single start pulse launches a sweep. For each step the engine places the step's phase, in whole degrees, on its phase output. It then raises a test request and waits for the external logic that runs the card-level test command to answer with a done pulse and a pass bit.

Passing steps that follow one another form windows. Once a step fails, nearby steps are not worth testing, so the engine jumps ahead by a fixed angle of about twenty degrees. It still always tests the final step. A window that runs off the end of the sweep and continues at step 0 is joined into a single window. The engine then picks the middle of the longest window. If every step passes, it uses a supplied default phase instead. If no step passes, it raises an error flag. A one-cycle done pulse marks the end of the sweep, and the phase output then holds the chosen value.

The number of steps N is a parameter with a default of 360. The default phase arrives on an input port; 0 is the usual value.

Top module: `phase_sweep_tuner`

## Requirements
- R1: Step index i is presented on `phase_deg` as ceil(i*360/N) degrees. The value is registered and already stable in the cycle before `test_req` rises, and it does not change while `test_req` is high.
- R2: `test_req` stays high until a cycle in which `test_done` is high. `test_pass` is sampled in that cycle, and `test_req` is low in the next cycle.
- R3: After a pass at index i, the next tested index is i+1.
- R4: After a fail at index i < N-1, the next tested index is i+ceil(20*N/360), clamped to N-1. Index N-1 is therefore always tested, and a result at N-1 ends the sweep.
- R5: A pass at step 0, or a pass that follows a fail, opens a new window. Each further pass moves that window's end to the current index.
- R6: When there is more than one window and both step 0 and step N-1 passed, the last window's start becomes the first window's start, and the last window is dropped.
- R7: When no step passes, `err` is raised together with `done`. It holds until the next accepted start, which clears it.
- R8: When the first window covers indices 0 through N-1, `phase_deg` takes the value of `default_phase`.
- R9: Window length is end-start+1, with N added when that is negative. The longest window is chosen, and the earlier window wins a tie. The result index is (start + length/2) mod N, converted as in R1.
- R10: `done` is a one-cycle pulse with `test_req` low. `phase_deg` keeps its final value afterwards.
- R11: A start pulse that arrives while a sweep is running has no effect: no extra steps and no change to the sequence.
- R12: After reset, `test_req`, `done` and `err` are 0 and `phase_deg` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a sweep when idle |
| default_phase | input | 9 | Phase in degrees used when every step passes |
| test_req | output | 1 | Asks for a test at the current phase |
| test_done | input | 1 | Test result is valid this cycle |
| test_pass | input | 1 | Test passed (valid with test_done) |
| phase_deg | output | 9 | Sampling phase in degrees |
| done | output | 1 | One-cycle pulse at the end of the sweep |
| err | output | 1 | No passing step found in the last sweep |

## Verification
Two events can land in the same cycle: a test result arriving on `test_done` and a fresh `start` pulse, because the responder can answer at the very moment the engine is deciding its next step. The bench provokes this by driving `start` high in every cycle in which it returns a result during one sweep, including the result at step N-1 that ends the sweep. It also pulses `start` once in the middle of the sweep. The bench judges the outcome by whether the sequence of tested phases and the final phase still match a sweep that received only one start. Any restart would add steps that the scoreboard does not expect.

// File: rtl/phase_sweep_tuner.sv
module phase_sweep_tuner #(
  parameter int N     = 360,
  parameter int DEG_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DEG_W-1:0] default_phase,
  output logic             test_req,
  input  logic             test_done,
  input  logic             test_pass,
  output logic [DEG_W-1:0] phase_deg,
  output logic             done,
  output logic             err
);

  localparam int IW     = $clog2(N + 1);
  localparam int LW     = IW + 1;
  localparam int MAXW   = N / 2 + 1;
  localparam int CW     = $clog2(MAXW + 1);
  localparam int WSLOTS = 1 << CW;
  localparam int SKIP   = (20 * N + 359) / 360;

  localparam logic [IW-1:0] LAST  = IW'(N - 1);
  localparam logic [LW-1:0] N_L   = LW'(N);
  localparam logic [LW-1:0] SKIPL = LW'(SKIP);
  localparam logic [LW-1:0] ONE_L = LW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_ARM, S_WAIT, S_POST, S_CHK, S_SCAN, S_FIN
  } state_t;

  function automatic logic [DEG_W-1:0] to_deg(input logic [IW-1:0] i);
    return DEG_W'((32'(i) * 360 + N - 1) / N);
  endfunction

  state_t            state;
  logic [IW-1:0]     idx;
  logic              prev_v, first_v, last_v;
  logic [CW-1:0]     cnt, scan_k;
  logic [LW-1:0]     best_len;
  logic [IW-1:0]     best_st;
  logic [DEG_W-1:0]  phase_q;
  logic              req_q, done_q, err_q;

  logic [IW-1:0]     win_st [WSLOTS];
  logic [IW-1:0]     win_en [WSLOTS];

  logic              opening;
  logic [CW-1:0]     cnt_m1;
  logic [LW-1:0]     step_sum, nxt_idx;
  logic [IW-1:0]     cur_st, cur_en;
  logic [LW-1:0]     scan_len;
  logic [LW-1:0]     mid_sum, mid_idx;

  assign opening = !prev_v && test_pass;
  assign cnt_m1  = cnt - CW'(1);
  assign cur_st  = win_st[scan_k];
  assign cur_en  = win_en[scan_k];

  always_comb begin
    step_sum = {1'b0, idx} + SKIPL;
    if (test_pass)
      nxt_idx = {1'b0, idx} + ONE_L;
    else if (idx == LAST)
      nxt_idx = N_L;
    else if (step_sum > {1'b0, LAST})
      nxt_idx = {1'b0, LAST};
    else
      nxt_idx = step_sum;
  end

  always_comb begin
    if (cur_en >= cur_st)
      scan_len = {1'b0, cur_en} - {1'b0, cur_st} + ONE_L;
    else
      scan_len = {1'b0, cur_en} + N_L + ONE_L - {1'b0, cur_st};
  end

  always_comb begin
    mid_sum = {1'b0, best_st} + (best_len >> 1);
    mid_idx = (mid_sum >= N_L) ? mid_sum - N_L : mid_sum;
  end

  always_ff @(posedge clk) begin
    if (state == S_WAIT && test_done && test_pass) begin
      if (opening) begin
        win_st[cnt] <= idx;
        win_en[cnt] <= idx;
      end else begin
        win_en[cnt_m1] <= idx;
      end
    end else if (state == S_POST && cnt > CW'(1) && first_v && last_v) begin
      win_st[0] <= win_st[cnt_m1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      idx      <= '0;
      prev_v   <= 1'b0;
      first_v  <= 1'b0;
      last_v   <= 1'b0;
      cnt      <= '0;
      scan_k   <= '0;
      best_len <= '0;
      best_st  <= '0;
      phase_q  <= '0;
      req_q    <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          idx     <= '0;
          prev_v  <= 1'b0;
          cnt     <= '0;
          err_q   <= 1'b0;
          phase_q <= to_deg('0);
          state   <= S_ARM;
        end
        S_ARM: begin
          req_q <= 1'b1;
          state <= S_WAIT;
        end
        S_WAIT: if (test_done) begin
          req_q  <= 1'b0;
          prev_v <= test_pass;
          last_v <= test_pass;
          if (idx == '0) first_v <= test_pass;
          if (opening) cnt <= cnt + CW'(1);
          if (nxt_idx >= N_L) begin
            state <= S_POST;
          end else begin
            idx     <= nxt_idx[IW-1:0];
            phase_q <= to_deg(nxt_idx[IW-1:0]);
            state   <= S_ARM;
          end
        end
        S_POST: begin
          if (cnt == '0) begin
            err_q  <= 1'b1;
            done_q <= 1'b1;
            state  <= S_IDLE;
          end else begin
            if (cnt > CW'(1) && first_v && last_v) cnt <= cnt_m1;
            state <= S_CHK;
          end
        end
        S_CHK: begin
          if (win_st[0] == '0 && win_en[0] == LAST) begin
            phase_q <= default_phase;
            done_q  <= 1'b1;
            state   <= S_IDLE;
          end else begin
            scan_k   <= '0;
            best_len <= '0;
            best_st  <= '0;
            state    <= S_SCAN;
          end
        end
        S_SCAN: begin
          if (scan_len > best_len) begin
            best_len <= scan_len;
            best_st  <= cur_st;
          end
          if (scan_k == cnt_m1) state <= S_FIN;
          else scan_k <= scan_k + CW'(1);
        end
        S_FIN: begin
          phase_q <= to_deg(mid_idx[IW-1:0]);
          done_q  <= 1'b1;
          state   <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign test_req  = req_q;
  assign phase_deg = phase_q;
  assign done      = done_q;
  assign err       = err_q;

endmodule

// File: rtl/phase_sweep_tuner_chk.sv
module phase_sweep_tuner_chk #(
  parameter int DEG_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             test_req,
  input logic             test_done,
  input logic [DEG_W-1:0] phase_deg,
  input logic             done,
  input logic             err
);

  AST_REQ_HELD:      assert property (@(posedge clk) disable iff (!rst_n) test_req && !test_done |=> test_req);              // R2
  AST_REQ_RELEASED:  assert property (@(posedge clk) disable iff (!rst_n) test_req && test_done |=> !test_req);              // R2
  AST_PHASE_READY:   assert property (@(posedge clk) disable iff (!rst_n) $rose(test_req) |-> $stable(phase_deg));          // R1
  AST_PHASE_STEADY:  assert property (@(posedge clk) disable iff (!rst_n) test_req && !test_done |=> $stable(phase_deg));   // R1
  AST_DONE_PULSE:    assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);                                  // R10
  AST_DONE_NO_REQ:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !test_req);                              // R10
  AST_ERR_AT_DONE:   assert property (@(posedge clk) disable iff (!rst_n) $rose(err) |-> done);                             // R7
  AST_ERR_KEPT:      assert property (@(posedge clk) disable iff (!rst_n) err && !start |=> err);                           // R7

endmodule

bind phase_sweep_tuner phase_sweep_tuner_chk #(.DEG_W(DEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .test_req(test_req),
  .test_done(test_done), .phase_deg(phase_deg), .done(done), .err(err)
);

// File: tb/sim_phase_sweep_tuner.sv
`timescale 1ns/1ps
module sim_phase_sweep_tuner;
  localparam int NB = 100;
  localparam int SK = (20 * NB + 359) / 360;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_drv = 1'b0, start_inj = 1'b0;
  logic start;
  logic [8:0] default_phase = '0;
  logic test_req, test_done = 1'b0, test_pass = 1'b0;
  logic [8:0] phase_deg;
  logic done, err;

  assign start = start_drv | start_inj;

  always #2.5 clk = ~clk;

  phase_sweep_tuner #(.N(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .default_phase(default_phase),
    .test_req(test_req), .test_done(test_done), .test_pass(test_pass),
    .phase_deg(phase_deg), .done(done), .err(err)
  );

  int checks = 0, errors = 0;
  bit pat [0:NB-1];
  int exp_q[$];
  int exp_phase;
  bit exp_err;
  string step_tag = "R12";
  bit inject = 1'b0;

  function automatic int degf(int i);
    return (i * 360 + NB - 1) / NB;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic fill(int lo, int hi, bit v);
    for (int i = lo; i <= hi; i++) pat[i] = v;
  endtask

  task automatic model(int dflt);
    int ws[0:NB];
    int we[0:NB];
    int i, cnt, len, blen, bst, mid;
    bit prev, first, v;
    exp_q.delete();
    i = 0; cnt = 0; prev = 0; first = 0; v = 0;
    while (i < NB) begin
      exp_q.push_back(degf(i));
      v = pat[i];
      if (i == 0) first = v;
      if (!prev && v) begin ws[cnt] = i; cnt++; end
      if (v) begin we[cnt-1] = i; i++; end
      else if (i == NB - 1) i++;
      else begin i += SK; if (i >= NB) i = NB - 1; end
      prev = v;
    end
    exp_err = (cnt == 0);
    exp_phase = 0;
    if (cnt == 0) return;
    if (cnt > 1 && first && v) begin ws[0] = ws[cnt-1]; cnt--; end
    if (ws[0] == 0 && we[0] == NB - 1) begin exp_phase = dflt; return; end
    blen = -1; bst = 0;
    for (int k = 0; k < cnt; k++) begin
      len = we[k] - ws[k] + 1;
      if (len < 0) len += NB;
      if (len > blen) begin blen = len; bst = ws[k]; end
    end
    mid = (bst + blen / 2) % NB;
    exp_phase = degf(mid);
  endtask

  // responder: answers each request after a varying latency
  initial begin
    int lat = 0;
    int idx;
    forever begin
      @(negedge clk);
      if (test_req) begin
        repeat (lat) @(negedge clk);
        idx = -1;
        for (int i = 0; i < NB; i++) if (degf(i) == int'(phase_deg)) idx = i;
        test_pass = (idx >= 0) ? pat[idx] : 1'b0;
        test_done = 1'b1;
        start_inj = inject;
        @(negedge clk);
        test_done = 1'b0;
        test_pass = 1'b0;
        start_inj = 1'b0;
        chk(!test_req, "R2", int'(test_req), 0);
        lat = (lat + 1) % 4;
      end
    end
  end

  // monitor: pops expected step phases as requests appear
  bit req_seen = 1'b0;
  int last_phase = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (test_req && !req_seen) begin
        req_seen = 1'b1;
        chk(int'(phase_deg) == last_phase, "R1", int'(phase_deg), last_phase);
        if (exp_q.size() == 0) chk(1'b0, {step_tag, " R11"}, int'(phase_deg), -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(phase_deg) == e, step_tag, int'(phase_deg), e);
        end
      end
      if (!test_req) req_seen = 1'b0;
      last_phase = int'(phase_deg);
    end
  end

  task automatic run_case(string stag, string rtag, int dflt, bit inj);
    int k;
    default_phase = 9'(dflt);
    model(dflt);
    step_tag = stag;
    @(negedge clk); start_drv = 1'b1;
    @(negedge clk); start_drv = 1'b0;
    chk(err == 1'b0, "R7", int'(err), 0);
    inject = inj;
    k = 0;
    while (!done && k < 20000) begin
      start_drv = inj && (k == 40);
      @(negedge clk);
      k++;
    end
    start_drv = 1'b0;
    inject = 1'b0;
    chk(int'(phase_deg) == exp_phase || exp_err, rtag, int'(phase_deg), exp_phase);
    chk(err == exp_err, exp_err ? "R7" : rtag, int'(err), int'(exp_err));
    chk(exp_q.size() == 0, stag, exp_q.size(), 0);
    chk(!test_req, "R10", int'(test_req), 0);
    @(negedge clk);
    chk(!done, "R10", int'(done), 0);
    chk(int'(phase_deg) == exp_phase || exp_err, "R10", int'(phase_deg), exp_phase);
    repeat (5) @(negedge clk);
    chk(!test_req, "R11", int'(test_req), 0);
    if (exp_err) chk(err, "R7", int'(err), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!test_req && !done && !err && phase_deg == 0, "R12", int'(phase_deg), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!test_req && !done && !err && phase_deg == 0, "R12", int'(phase_deg), 0);

    fill(0, NB-1, 1'b1);
    run_case("R3", "R8", 45, 1'b0);

    fill(0, NB-1, 1'b0);
    run_case("R4", "R7", 45, 1'b0);

    fill(0, NB-1, 1'b0); fill(20, 39, 1'b1);
    run_case("R5", "R9", 45, 1'b0);

    fill(0, NB-1, 1'b0); fill(0, 9, 1'b1); fill(50, 54, 1'b1); fill(90, 99, 1'b1);
    run_case("R5", "R6", 77, 1'b0);

    fill(0, NB-1, 1'b0); fill(10, 19, 1'b1); fill(60, 69, 1'b1);
    run_case("R3", "R9", 77, 1'b0);

    fill(0, NB-1, 1'b0); pat[NB-1] = 1'b1;
    run_case("R4", "R9", 77, 1'b0);

    fill(0, NB-1, 1'b0); fill(30, 60, 1'b1); pat[NB-1] = 1'b1;
    run_case("R11", "R11", 12, 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule